// File: doc/BRIEF.md
# Shadow Region Route Decoder

This block looks at one host memory address and says where the access goes: to internal DRAM or out to the external bus. It gives one answer for reads and a separate answer for writes. The legacy area 0xC0000 to 0xFFFFF is cut into sixteen 16 KB segments. Each segment has its own read-enable bit and its own write-enable bit. Those bits sit in four byte-wide shadow registers that a register file supplies. A hole-control byte covers four more windows. Two are fixed: 0x80000 to 0x9FFFF and 0xA0000 to 0xBFFFF. Two depend on installed memory: 0xE00000 to 0xEFFFFF and 0xF00000 to 0xFFFFFF. Any address outside all of these windows stays internal.

A read/write strobe picks which of the two answers appears on a third output, so the memory controller can use that output directly. Two summary flags report whether any of the top four segments (0xF0000 to 0xFFFFF) is shadowed, one flag for read and one for write. The parameter `REG_OUT` chooses between a purely combinational decode and a version with one register stage on every output.

Top module: `shadow_route_dec`

## Requirements
- R1: For an address in 0xC0000..0xDFFFF, with segment index k = (address - 0xC0000) / 0x4000 (0..7), the read route is internal (rd_int_o = 1) exactly when shad_rd_lo_i[k] is 1. A 0 bit routes the read externally (rd_int_o = 0).
- R2: In the same range, the write route is internal (wr_int_o = 1) exactly when shad_wr_lo_i[k] is 1.
- R3: For an address in 0xE0000..0xFFFFF, with k = (address - 0xE0000) / 0x4000, the read route follows shad_rd_hi_i[k] and the write route follows shad_wr_hi_i[k], with the same encoding as R1.
- R4: bios_rd_shadow_o is the OR of shad_rd_hi_i[7:4]. bios_wr_shadow_o is the OR of shad_wr_hi_i[7:4].
- R5: For an address in 0xA0000..0xBFFFF, reads and writes are both internal when hole_ctl_i[3] is 1 and both external when it is 0.
- R6: For an address in 0x80000..0x9FFFF, reads and writes are both internal when hole_ctl_i[2] is 1 and both external when it is 0.
- R7: For an address in 0xE00000..0xEFFFFF with mem_mb_i greater than 14, both routes are external when hole_ctl_i[5] is 1 and internal when it is 0. With mem_mb_i of 14 or less, the range routes internally whatever that bit holds.
- R8: For an address in 0xF00000..0xFFFFFF with mem_mb_i greater than 15, both routes are external when hole_ctl_i[4] is 1 and internal when it is 0. With mem_mb_i of 15 or less, the range routes internally.
- R9: Every other address routes internally for both read and write. hole_ctl_i bits 0, 1, 6 and 7 have no effect on any output.
- R10: acc_int_o equals wr_int_o when acc_wr_i is 1 and equals rd_int_o when acc_wr_i is 0.
- R11: With REG_OUT = 1, every output shows the decode of the inputs seen at the previous rising clock edge. While rst_ni is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, used by the output register option and by the checks |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W (24) | Host byte address |
| acc_wr_i | input | 1 | 1 = current access is a write, 0 = read |
| shad_rd_lo_i | input | SEGS_PER_REG (8) | Read enables, segments 0xC0000..0xDFFFF |
| shad_rd_hi_i | input | SEGS_PER_REG (8) | Read enables, segments 0xE0000..0xFFFFF |
| shad_wr_lo_i | input | SEGS_PER_REG (8) | Write enables, segments 0xC0000..0xDFFFF |
| shad_wr_hi_i | input | SEGS_PER_REG (8) | Write enables, segments 0xE0000..0xFFFFF |
| hole_ctl_i | input | 8 | Hole control byte (bits 2..5 used) |
| mem_mb_i | input | MEM_W (8) | Installed memory in MB |
| rd_int_o | output | 1 | Read of addr_i goes to internal DRAM |
| wr_int_o | output | 1 | Write of addr_i goes to internal DRAM |
| acc_int_o | output | 1 | Route for the direction selected by acc_wr_i |
| bios_rd_shadow_o | output | 1 | Top 64 KB shadowed for read |
| bios_wr_shadow_o | output | 1 | Top 64 KB shadowed for write |

## Verification
Addresses are drawn from the legacy segments, the two low holes, the two high holes, the whole 16 MB space, and the edges between windows. Segment enables are random and the read and write banks differ, so a swapped bank or a wrong segment index shows up. Memory sizes run from 12 to 17 MB, which puts 14 and 15 MB on both sides of each high-hole threshold. Hole bytes with the unused bits set separate a correct bit pick from a neighbouring one. Both output variants are driven at once, and the registered one is compared one edge later, which catches a missing or doubled stage.

// File: rtl/shadow_route_pkg.sv
package shadow_route_pkg;

   typedef struct packed {
      logic rd;
      logic wr;
   } route_t;

   localparam int unsigned LEGACY_BASE   = 32'h000C_0000;
   localparam int unsigned LOW_HOLE_LOG2 = 17;
   localparam int unsigned VGA_BASE      = 32'h000A_0000;
   localparam int unsigned DOS_TOP_BASE  = 32'h0008_0000;
   localparam int unsigned HI_HOLE_LOG2  = 20;
   localparam int unsigned HI_E_BASE     = 32'h00E0_0000;
   localparam int unsigned HI_F_BASE     = 32'h00F0_0000;

   localparam int unsigned HC_DOS_BIT = 2;
   localparam int unsigned HC_VGA_BIT = 3;
   localparam int unsigned HC_F_BIT   = 4;
   localparam int unsigned HC_E_BIT   = 5;

   localparam route_t ROUTE_INT = '{rd: 1'b1, wr: 1'b1};

endpackage

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode
   import shadow_route_pkg::*;
#(
   parameter int ADDR_W       = 24,
   parameter int SEG_LOG2     = 14,
   parameter int SEGS_PER_REG = 8
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic [SEGS_PER_REG-1:0] rd_lo_i,
   input  logic [SEGS_PER_REG-1:0] rd_hi_i,
   input  logic [SEGS_PER_REG-1:0] wr_lo_i,
   input  logic [SEGS_PER_REG-1:0] wr_hi_i,
   output logic                    hit_o,
   output route_t                  route_o
);

   localparam int TOT_SEGS     = 2 * SEGS_PER_REG;
   localparam int IDX_W        = $clog2(TOT_SEGS);
   localparam int REGION_SHIFT = SEG_LOG2 + IDX_W;
   localparam int REGION_TAG   = int'(LEGACY_BASE >> REGION_SHIFT);

   initial begin : elab_chk
      assert ((LEGACY_BASE % (32'd1 << REGION_SHIFT)) == 0)
         else $error("legacy base not aligned to segment region");
      assert (TOT_SEGS == (1 << IDX_W))
         else $error("segment count must be a power of two");
   end

   logic [ADDR_W-1:0]   region_tag;
   logic [IDX_W-1:0]    seg_idx;
   logic [TOT_SEGS-1:0] seg_sel;
   logic [TOT_SEGS-1:0] rd_en_vec;
   logic [TOT_SEGS-1:0] wr_en_vec;

   assign region_tag = addr_i >> REGION_SHIFT;
   assign seg_idx    = IDX_W'(addr_i >> SEG_LOG2);
   assign hit_o      = (region_tag == ADDR_W'(REGION_TAG));
   assign rd_en_vec  = {rd_hi_i, rd_lo_i};
   assign wr_en_vec  = {wr_hi_i, wr_lo_i};

   generate
      for (genvar g = 0; g < TOT_SEGS; g++) begin : g_seg
         assign seg_sel[g] = hit_o && (seg_idx == IDX_W'(g));
      end
   endgenerate

   assign route_o.rd = |(seg_sel & rd_en_vec);
   assign route_o.wr = |(seg_sel & wr_en_vec);

   // R1 / R3: a cleared read bit must never yield an internal read
   assert_seg_rd_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_o && !rd_en_vec[seg_idx]) |-> !route_o.rd);
   // R2: a set write bit must give an internal write
   assert_seg_wr_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_o && wr_en_vec[seg_idx]) |-> route_o.wr);
   // R3: at most one segment is selected
   assert_seg_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(seg_sel));

endmodule

// File: rtl/shadow_hole_decode.sv
module shadow_hole_decode
   import shadow_route_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int MEM_W      = 8,
   parameter int E_LIMIT_MB = 14,
   parameter int F_LIMIT_MB = 15
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [3:0]       ctl_i,      // hole control bits 5..2
   input  logic [MEM_W-1:0] mem_mb_i,
   output logic             hit_o,
   output route_t           route_o
);

   localparam int VGA_TAG = int'(VGA_BASE >> LOW_HOLE_LOG2);
   localparam int DOS_TAG = int'(DOS_TOP_BASE >> LOW_HOLE_LOG2);
   localparam int E_TAG   = int'(HI_E_BASE >> HI_HOLE_LOG2);
   localparam int F_TAG   = int'(HI_F_BASE >> HI_HOLE_LOG2);
   localparam int CTL_LSB = HC_DOS_BIT;

   initial begin : elab_chk
      assert (ADDR_W >= 24) else $error("address must cover 16 MB");
      assert (E_LIMIT_MB < (1 << MEM_W) && F_LIMIT_MB < (1 << MEM_W))
         else $error("memory limits exceed MEM_W");
   end

   logic [ADDR_W-1:0] low_tag, high_tag;
   logic in_vga, in_dos, in_e, in_f, e_live, f_live;
   logic ctl_vga, ctl_dos, ctl_e, ctl_f;
   logic hole_int;

   assign low_tag  = addr_i >> LOW_HOLE_LOG2;
   assign high_tag = addr_i >> HI_HOLE_LOG2;
   assign in_vga   = (low_tag == ADDR_W'(VGA_TAG));
   assign in_dos   = (low_tag == ADDR_W'(DOS_TAG));
   assign in_e     = (high_tag == ADDR_W'(E_TAG));
   assign in_f     = (high_tag == ADDR_W'(F_TAG));
   assign e_live   = in_e && (mem_mb_i > MEM_W'(E_LIMIT_MB));
   assign f_live   = in_f && (mem_mb_i > MEM_W'(F_LIMIT_MB));

   assign ctl_dos = ctl_i[HC_DOS_BIT - CTL_LSB];
   assign ctl_vga = ctl_i[HC_VGA_BIT - CTL_LSB];
   assign ctl_f   = ctl_i[HC_F_BIT - CTL_LSB];
   assign ctl_e   = ctl_i[HC_E_BIT - CTL_LSB];

   always_comb begin
      hole_int = 1'b1;
      if (in_vga)      hole_int = ctl_vga;
      else if (in_dos) hole_int = ctl_dos;
      else if (e_live) hole_int = !ctl_e;
      else if (f_live) hole_int = !ctl_f;
   end

   assign hit_o      = in_vga | in_dos | e_live | f_live;
   assign route_o.rd = hole_int;
   assign route_o.wr = hole_int;

   // R5: holes route reads and writes the same way
   assert_hole_sym_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o |-> (route_o.rd == route_o.wr));
   // R7: the 0xE00000 window is inert when memory is small
   assert_e_small_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_e && mem_mb_i <= MEM_W'(E_LIMIT_MB)) |-> !hit_o);
   // R8: the 0xF00000 window is inert when memory is small
   assert_f_small_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_f && mem_mb_i <= MEM_W'(F_LIMIT_MB)) |-> !hit_o);

endmodule

// File: rtl/shadow_route_merge.sv
module shadow_route_merge
   import shadow_route_pkg::*;
(
   input  logic   clk_i,
   input  logic   rst_ni,
   input  logic   seg_hit_i,
   input  route_t seg_route_i,
   input  logic   hole_hit_i,
   input  route_t hole_route_i,
   input  logic   acc_wr_i,
   output route_t route_o,
   output logic   acc_int_o
);

   always_comb begin
      route_o = ROUTE_INT;
      if (seg_hit_i)       route_o = seg_route_i;
      else if (hole_hit_i) route_o = hole_route_i;
   end

   assign acc_int_o = acc_wr_i ? route_o.wr : route_o.rd;

   // R9: no window hit means internal both ways
   assert_default_int_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!seg_hit_i && !hole_hit_i) |-> (route_o.rd && route_o.wr));
   // R10: the access output tracks the write route on writes
   assert_acc_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_wr_i |-> (acc_int_o == route_o.wr));
   // R1: windows never overlap
   assert_no_overlap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(seg_hit_i && hole_hit_i));

endmodule

// File: rtl/shadow_route_dec.sv
module shadow_route_dec
   import shadow_route_pkg::*;
#(
   parameter int ADDR_W       = 24,
   parameter int SEG_LOG2     = 14,
   parameter int SEGS_PER_REG = 8,
   parameter int MEM_W        = 8,
   parameter int E_LIMIT_MB   = 14,
   parameter int F_LIMIT_MB   = 15,
   parameter bit REG_OUT      = 1'b0
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic                    acc_wr_i,
   input  logic [SEGS_PER_REG-1:0] shad_rd_lo_i,
   input  logic [SEGS_PER_REG-1:0] shad_rd_hi_i,
   input  logic [SEGS_PER_REG-1:0] shad_wr_lo_i,
   input  logic [SEGS_PER_REG-1:0] shad_wr_hi_i,
   input  logic [7:0]              hole_ctl_i,
   input  logic [MEM_W-1:0]        mem_mb_i,
   output logic                    rd_int_o,
   output logic                    wr_int_o,
   output logic                    acc_int_o,
   output logic                    bios_rd_shadow_o,
   output logic                    bios_wr_shadow_o
);

   localparam int BIOS_LSB = SEGS_PER_REG / 2;

   initial begin : elab_chk
      assert (SEGS_PER_REG >= 2 && SEGS_PER_REG % 2 == 0)
         else $error("SEGS_PER_REG must be even");
      assert (SEG_LOG2 + $clog2(2 * SEGS_PER_REG) == 18)
         else $error("segments must tile 0xC0000..0xFFFFF");
   end

   logic   seg_hit, hole_hit;
   route_t seg_route, hole_route, route_d;
   logic   acc_d, bios_rd_d, bios_wr_d;
   logic   unused_ctl;

   assign unused_ctl = ^{hole_ctl_i[7:6], hole_ctl_i[1:0]};

   shadow_seg_decode #(
      .ADDR_W(ADDR_W), .SEG_LOG2(SEG_LOG2), .SEGS_PER_REG(SEGS_PER_REG)
   ) u_seg (
      .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i),
      .rd_lo_i(shad_rd_lo_i), .rd_hi_i(shad_rd_hi_i),
      .wr_lo_i(shad_wr_lo_i), .wr_hi_i(shad_wr_hi_i),
      .hit_o(seg_hit), .route_o(seg_route)
   );

   shadow_hole_decode #(
      .ADDR_W(ADDR_W), .MEM_W(MEM_W),
      .E_LIMIT_MB(E_LIMIT_MB), .F_LIMIT_MB(F_LIMIT_MB)
   ) u_hole (
      .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i),
      .ctl_i(hole_ctl_i[HC_E_BIT:HC_DOS_BIT]), .mem_mb_i(mem_mb_i),
      .hit_o(hole_hit), .route_o(hole_route)
   );

   shadow_route_merge u_merge (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .seg_hit_i(seg_hit), .seg_route_i(seg_route),
      .hole_hit_i(hole_hit), .hole_route_i(hole_route),
      .acc_wr_i(acc_wr_i), .route_o(route_d), .acc_int_o(acc_d)
   );

   assign bios_rd_d = |shad_rd_hi_i[SEGS_PER_REG-1:BIOS_LSB];
   assign bios_wr_d = |shad_wr_hi_i[SEGS_PER_REG-1:BIOS_LSB];

   // R4: no upper enables means no summary flag
   assert_bios_rd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (shad_rd_hi_i[SEGS_PER_REG-1:BIOS_LSB] == '0) |-> !bios_rd_d);
   assert_bios_wr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(bios_wr_d) |-> (shad_wr_hi_i != '0));

   generate
      if (REG_OUT) begin : g_reg
         logic past_ok;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               rd_int_o         <= 1'b0;
               wr_int_o         <= 1'b0;
               acc_int_o        <= 1'b0;
               bios_rd_shadow_o <= 1'b0;
               bios_wr_shadow_o <= 1'b0;
               past_ok          <= 1'b0;
            end else begin
               rd_int_o         <= route_d.rd;
               wr_int_o         <= route_d.wr;
               acc_int_o        <= acc_d;
               bios_rd_shadow_o <= bios_rd_d;
               bios_wr_shadow_o <= bios_wr_d;
               past_ok          <= 1'b1;
            end
         end
         // R11: registered outputs lag the decode by one edge
         assert_reg_lag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
            past_ok |-> (rd_int_o == $past(route_d.rd) && wr_int_o == $past(route_d.wr)
                         && acc_int_o == $past(acc_d)));
      end else begin : g_comb
         assign rd_int_o         = route_d.rd;
         assign wr_int_o         = route_d.wr;
         assign acc_int_o        = acc_d;
         assign bios_rd_shadow_o = bios_rd_d;
         assign bios_wr_shadow_o = bios_wr_d;
      end
   endgenerate

endmodule

// File: tb/shadow_route_dec_bench.sv
`timescale 1ns/1ps
module shadow_route_dec_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] addr = '0;
   logic        wr = 1'b0;
   logic [7:0]  rlo = '0, rhi = '0, wlo = '0, whi = '0, hc = '0, mem = 8'd16;
   logic c_rd, c_wr, c_acc, c_brd, c_bwr;
   logic r_rd, r_wr, r_acc, r_brd, r_bwr;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   shadow_route_dec u_shadow_route_dec (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .acc_wr_i(wr),
      .shad_rd_lo_i(rlo), .shad_rd_hi_i(rhi), .shad_wr_lo_i(wlo), .shad_wr_hi_i(whi),
      .hole_ctl_i(hc), .mem_mb_i(mem),
      .rd_int_o(c_rd), .wr_int_o(c_wr), .acc_int_o(c_acc),
      .bios_rd_shadow_o(c_brd), .bios_wr_shadow_o(c_bwr));

   shadow_route_dec #(.REG_OUT(1'b1)) u_shadow_route_dec_reg (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .acc_wr_i(wr),
      .shad_rd_lo_i(rlo), .shad_rd_hi_i(rhi), .shad_wr_lo_i(wlo), .shad_wr_hi_i(whi),
      .hole_ctl_i(hc), .mem_mb_i(mem),
      .rd_int_o(r_rd), .wr_int_o(r_wr), .acc_int_o(r_acc),
      .bios_rd_shadow_o(r_brd), .bios_wr_shadow_o(r_bwr));

   // expected route for one direction, given that direction's two banks
   function automatic bit exp_int(input logic [23:0] a, input logic [7:0] lo,
                                  input logic [7:0] hi, input logic [7:0] h,
                                  input logic [7:0] m);
      int k;
      if (a >= 24'h0C0000 && a <= 24'h0FFFFF) begin
         k = int'((a - 24'h0C0000) / 24'h4000);
         return (k < 8) ? lo[k] : hi[k-8];
      end
      if (a >= 24'h0A0000 && a <= 24'h0BFFFF) return h[3];
      if (a >= 24'h080000 && a <= 24'h09FFFF) return h[2];
      if (a >= 24'hE00000 && a <= 24'hEFFFFF && m > 14) return !h[5];
      if (a >= 24'hF00000 && m > 15) return !h[4];
      return 1'b1;
   endfunction

   function automatic string req_of(input logic [23:0] a, input bit is_wr);
      if (a >= 24'h0C0000 && a <= 24'h0DFFFF) return is_wr ? "R2" : "R1";
      if (a >= 24'h0E0000 && a <= 24'h0FFFFF) return "R3";
      if (a >= 24'h0A0000 && a <= 24'h0BFFFF) return "R5";
      if (a >= 24'h080000 && a <= 24'h09FFFF) return "R6";
      if (a >= 24'hE00000 && a <= 24'hEFFFFF) return "R7";
      if (a >= 24'hF00000) return "R8";
      return "R9";
   endfunction

   task automatic check(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s addr=%h actual=%b expected=%b", req, what, addr, act, exp);
      end
   endtask

   task automatic check_set(input string tag, input logic rd, input logic wrr, input logic acc,
                            input logic brd, input logic bwr);
      bit er, ew;
      er = exp_int(addr, rlo, rhi, hc, mem);
      ew = exp_int(addr, wlo, whi, hc, mem);
      check(req_of(addr, 1'b0), {tag, " rd"}, rd, er);
      check(req_of(addr, 1'b1), {tag, " wr"}, wrr, ew);
      check("R10", {tag, " acc"}, acc, wr ? ew : er);
      check("R4", {tag, " bios_rd"}, brd, |rhi[7:4]);
      check("R4", {tag, " bios_wr"}, bwr, |whi[7:4]);
   endtask

   task automatic apply(input logic [23:0] a, input bit w, input logic [7:0] rl,
                        input logic [7:0] rh, input logic [7:0] wl, input logic [7:0] wh,
                        input logic [7:0] h, input logic [7:0] m);
      @(negedge clk);
      addr = a; wr = w; rlo = rl; rhi = rh; wlo = wl; whi = wh; hc = h; mem = m;
      #1;
      check_set("comb", c_rd, c_wr, c_acc, c_brd, c_bwr);
      @(posedge clk);
      #1;
      check_set("R11 reg", r_rd, r_wr, r_acc, r_brd, r_bwr);
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [23:0] a;
      void'($urandom(32'h5EED_1234));
      // reset: registered variant holds zeros (R11)
      rlo = 8'hFF; rhi = 8'hFF; wlo = 8'hFF; whi = 8'hFF;
      repeat (3) @(negedge clk);
      check("R11", "reset rd", r_rd, 1'b0);
      check("R11", "reset wr", r_wr, 1'b0);
      check("R11", "reset acc", r_acc, 1'b0);
      check("R11", "reset bios_rd", r_brd, 1'b0);
      check("R11", "reset bios_wr", r_bwr, 1'b0);
      rst_n = 1'b1;

      // R1/R2: segment edges with different read and write banks
      apply(24'h0C0000, 0, 8'h01, 8'h00, 8'h02, 8'h00, 8'h00, 8'd16);
      apply(24'h0C3FFF, 1, 8'h01, 8'h00, 8'h02, 8'h00, 8'h00, 8'd16);
      apply(24'h0C4000, 1, 8'h01, 8'h00, 8'h02, 8'h00, 8'h00, 8'd16);
      apply(24'h0DFFFF, 0, 8'h80, 8'h00, 8'h7F, 8'h00, 8'h00, 8'd16);
      // R3/R4: upper bank and BIOS summary
      apply(24'h0E0000, 0, 8'hFF, 8'h01, 8'hFF, 8'h00, 8'h00, 8'd16);
      apply(24'h0FFFFF, 1, 8'h00, 8'h80, 8'h00, 8'h10, 8'h00, 8'd16);
      apply(24'h0F0000, 0, 8'h00, 8'h0F, 8'h00, 8'h0F, 8'hFF, 8'd16);
      // R5/R6: low holes, unused bits set (R9)
      apply(24'h0BFFFF, 0, 8'h00, 8'h00, 8'h00, 8'h00, 8'hC3, 8'd16);
      apply(24'h0A0000, 1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h08, 8'd16);
      apply(24'h080000, 1, 8'h00, 8'h00, 8'h00, 8'h00, 8'hF3, 8'd16);
      apply(24'h09FFFF, 0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h04, 8'd16);
      apply(24'h07FFFF, 0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'd16);
      // R7/R8: thresholds at 14 and 15 MB
      apply(24'hE00000, 0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h30, 8'd14);
      apply(24'hE00000, 0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h30, 8'd15);
      apply(24'hEFFFFF, 1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h10, 8'd15);
      apply(24'hF00000, 0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h30, 8'd15);
      apply(24'hFFFFFF, 1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h10, 8'd16);
      apply(24'hF00000, 0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h20, 8'd16);
      // R9: plain memory with every control bit set
      apply(24'h100000, 0, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'd16);

      for (int i = 0; i < 600; i++) begin
         case ($urandom % 6)
            0, 1: a = 24'h0C0000 + 24'($urandom % 32'h40000);
            2:    a = 24'h080000 + 24'($urandom % 32'h40000);
            3:    a = 24'hE00000 + 24'($urandom % 32'h200000);
            4:    a = 24'($urandom);
            default: a = 24'($urandom % 32'h100000);
         endcase
         apply(a, 1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
               8'($urandom), 8'(12 + $urandom % 6));
      end

      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule